// File: doc/BRIEF.md
# Strobe-Driven FIFO with Programmable Half-Full Threshold

This block is a first-in first-out buffer for 9-bit words, moved in and out by two active-low strobes instead of enable levels. All logic runs on one system clock. A falling edge on the write strobe, seen on that clock, stores the input word. A falling edge on the read strobe places the oldest stored word on the output bus. Three active-low flags report the fill state: empty, full, and a half-full flag whose threshold comes from a register rather than being fixed.

The threshold register is written only while the active-low reset is held. A write-strobe pulse during reset copies the input bus into the register. A read-strobe pulse during reset drives the register's contents onto the output bus, so the value can be checked. A reset with both strobes left high clears the pointers and the flags but keeps the threshold. Until the first reset after power-up, the block refuses every write. Until a threshold is first loaded, the threshold is half the depth.

Top module: `strobe_fifo`

## Requirements
- R1: When the full flag is high, a falling edge of `wr_n` stores `din`. When the empty flag is high, a falling edge of `rd_n` puts the oldest stored word on `dout` one clock later. Words leave in the order they were written.
- R2: A falling edge of `wr_n` while `ff_n` is low is ignored. No word is stored and none is lost.
- R3: A falling edge of `rd_n` while `ef_n` is low is ignored. `dout` keeps its value and the flags do not change.
- R4: One or more clocks with `rst_n` low empty the buffer. After reset, `ef_n` is low and both `ff_n` and `hf_n` are high.
- R5: Before the first clock with `rst_n` low, write strobes store nothing, so `ef_n` stays low.
- R6: A falling edge of `wr_n` while `rst_n` is low loads the threshold from all 9 bits of `din`, zero-extended.
- R7: A reset in which both strobes stay high leaves the threshold unchanged.
- R8: A falling edge of `rd_n` while `rst_n` is low drives the low 9 bits of the current threshold onto `dout`.
- R9: `hf_n` is low exactly when the stored word count is greater than the threshold. Before any threshold is loaded, the threshold is DEPTH/2.
- R10: `ff_n` is low exactly when DEPTH words are stored. `ef_n` is low exactly when no word is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; strobes and reset are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset; also opens the threshold-load window |
| wr_n | input | 1 | Active-low write strobe, acts on its falling edge |
| rd_n | input | 1 | Active-low read strobe, acts on its falling edge |
| din | input | DATA_W | Data word to store, or new threshold while in reset |
| dout | output | DATA_W | Last word read, or threshold readback |
| ef_n | output | 1 | Active-low empty flag |
| ff_n | output | 1 | Active-low full flag |
| hf_n | output | 1 | Active-low flag, low while the count is above the threshold |

## Verification
The bench builds the block with DEPTH set to 16 and the default word width of 9. With this depth, the full flag and the refused write at full are reached within a few dozen strobes. It also leaves the default threshold of 8 small enough to read back whole on the 9-bit bus. Loaded thresholds above the depth, such as 0x1F5, can also be set, and those keep the half-full flag high at every fill level. The random phase mixes single and simultaneous strobes, so reads at empty and writes at full happen many times at the edges of the range.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

    // Falling-edge events of the two strobes, grouped for the control path.
    typedef struct packed {
        logic wr;
        logic rd;
    } strobe_fall_t;

endpackage

// File: rtl/strobe_edge.sv
module strobe_edge (
    input  logic clk,
    input  logic strobe_n,
    output logic fall
);

    // Edge history is not cleared by reset so that pulses inside reset are seen.
    logic prev_d;
    logic prev_q = 1'b1;

    always_comb begin
        prev_d = strobe_n;
    end

    always_ff @(posedge clk) begin
        prev_q <= prev_d;
    end

    assign fall = prev_q & ~strobe_n;

endmodule

// File: rtl/fifo_mem.sv
module fifo_mem #(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 2048,
    parameter int AW     = 11
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo #(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              ef_n,
    output logic              ff_n,
    output logic              hf_n
);
    import sfifo_pkg::*;

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;
    localparam int TW = (DATA_W > CW) ? DATA_W : CW;
    localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT  = CW'(DEPTH);
    localparam logic [TW-1:0] THR_INIT  = TW'(DEPTH / 2);

    typedef struct packed {
        logic [AW-1:0]     wptr;
        logic [AW-1:0]     rptr;
        logic [CW-1:0]     cnt;
        logic [TW-1:0]     thr;
        logic              thr_set;
        logic              armed;
        logic [DATA_W-1:0] dout;
    } state_t;

    state_t st_d;
    state_t st_q = '0;

    strobe_fall_t      fall;
    logic              do_wr;
    logic              do_rd;
    logic              empty;
    logic              full;
    logic [TW-1:0]     thr_eff;
    logic [DATA_W-1:0] rdata;

    strobe_edge u_wr_edge (.clk(clk), .strobe_n(wr_n), .fall(fall.wr));
    strobe_edge u_rd_edge (.clk(clk), .strobe_n(rd_n), .fall(fall.rd));

    fifo_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_mem (
        .clk   (clk),
        .we    (do_wr),
        .waddr (st_q.wptr),
        .wdata (din),
        .raddr (st_q.rptr),
        .rdata (rdata)
    );

    assign empty   = (st_q.cnt == '0);
    assign full    = (st_q.cnt == FULL_CNT);
    assign thr_eff = st_q.thr_set ? st_q.thr : THR_INIT;
    assign do_wr   = rst_n & fall.wr & st_q.armed & ~full;
    assign do_rd   = rst_n & fall.rd & ~empty;

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.wptr  = '0;
            st_d.rptr  = '0;
            st_d.cnt   = '0;
            st_d.armed = 1'b1;
            if (fall.wr) begin
                st_d.thr     = TW'(din);
                st_d.thr_set = 1'b1;
            end
            if (fall.rd) begin
                st_d.dout = thr_eff[DATA_W-1:0];
            end
        end else begin
            if (do_wr) begin
                st_d.wptr = (st_q.wptr == LAST_ADDR) ? '0 : st_q.wptr + 1'b1;
            end
            if (do_rd) begin
                st_d.dout = rdata;
                st_d.rptr = (st_q.rptr == LAST_ADDR) ? '0 : st_q.rptr + 1'b1;
            end
            case ({do_wr, do_rd})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign dout = st_q.dout;
    assign ef_n = ~empty;
    assign ff_n = ~full;
    assign hf_n = ~(TW'(st_q.cnt) > thr_eff);

    // After any reset cycle the buffer reports empty, not full, not half full.
    assert_reset_flags_R4: assert property (@(posedge clk)
        !rst_n |=> (!ef_n && ff_n && hf_n))
        else $error("reset flag state wrong");

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fall.wr && !fall.rd && !ff_n) |=> !ff_n)
        else $error("full flag dropped after refused write");

    assert_empty_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fall.rd && !ef_n) |=> $stable(dout))
        else $error("read at empty changed dout");

    assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ef_n && !ff_n))
        else $error("empty and full both asserted");

    assert_unarmed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.armed |=> !ef_n)
        else $error("word stored before first reset");

endmodule

// File: tb/tb_strobe_fifo.sv
module tb_strobe_fifo;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 9;
    localparam int DEPTH = 16;

    logic clk = 1'b0;
    logic rst_n, wr_n, rd_n;
    logic [DW-1:0] din;
    logic [DW-1:0] dout;
    logic ef_n, ff_n, hf_n;

    int n_checks = 0;
    int n_fail = 0;
    int q[$];
    int thr_m = DEPTH / 2;
    logic [DW-1:0] exp_dout = '0;
    bit dout_known = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    strobe_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .din(din),
        .dout(dout), .ef_n(ef_n), .ff_n(ff_n), .hf_n(hf_n)
    );

    function automatic logic exp_hf();
        return (q.size() > thr_m) ? 1'b0 : 1'b1;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk(req, "ef_n", int'(ef_n), (q.size() == 0) ? 0 : 1);
        chk(req, "ff_n", int'(ff_n), (q.size() == DEPTH) ? 0 : 1);
        chk(req, "hf_n", int'(hf_n), int'(exp_hf()));
        if (dout_known) chk(req, "dout", int'(dout), int'(exp_dout));
    endtask

    // Model update: read and write decided on the state before the strobe.
    task automatic strobe(input bit w, input bit r, input logic [DW-1:0] d);
        bit rd_ok = (q.size() > 0);
        bit wr_ok = (q.size() < DEPTH);
        @(negedge clk);
        din = d; wr_n = ~w; rd_n = ~r;
        @(negedge clk);
        wr_n = 1'b1; rd_n = 1'b1;
        if (r && rd_ok) begin
            exp_dout = DW'(q.pop_front());
            dout_known = 1'b1;
        end
        if (w && wr_ok) q.push_back(int'(d));
    endtask

    task automatic do_reset(input bit prog, input logic [DW-1:0] val, input bit rb);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        if (prog) begin
            din = val; wr_n = 1'b0;
            @(negedge clk);
            wr_n = 1'b1;
            @(negedge clk);
            thr_m = int'(val);
        end
        if (rb) begin
            rd_n = 1'b0;
            @(negedge clk);
            rd_n = 1'b1;
            @(negedge clk);
            exp_dout = DW'(thr_m);
            dout_known = 1'b1;
        end
        rst_n = 1'b1;
        q.delete();
        @(negedge clk);
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        report();
    end

    initial begin
        logic [DW-1:0] held;
        void'($urandom(32'd1234));
        rst_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1; din = '0;
        repeat (3) @(negedge clk);

        // R5: write before any reset is refused
        strobe(1'b1, 1'b0, 9'h055);
        q.delete();
        chk("R5", "ef_n before reset", int'(ef_n), 0);

        // R4: plain reset
        do_reset(1'b0, '0, 1'b0);
        chk("R4", "ef_n", int'(ef_n), 0);
        chk("R4", "ff_n", int'(ff_n), 1);
        chk("R4", "hf_n", int'(hf_n), 1);

        // R9/R10: default threshold DEPTH/2, fill to full
        for (int i = 0; i < DEPTH; i++) begin
            strobe(1'b1, 1'b0, DW'($urandom));
            chk("R9", "fill flags", int'(hf_n), int'(exp_hf()));
            chk_all("R10");
        end
        // R2: write at full ignored
        strobe(1'b1, 1'b0, 9'h1AB);
        chk("R2", "size after refused write", int'(ff_n), 0);
        chk_all("R2");
        // R1: drain, order preserved
        for (int i = 0; i < DEPTH; i++) begin
            strobe(1'b0, 1'b1, '0);
            chk_all("R1");
        end
        // R3: read at empty ignored
        held = dout;
        strobe(1'b0, 1'b1, '0);
        chk("R3", "dout held", int'(dout), int'(held));
        chk_all("R3");

        // R8: readback of default threshold, then R6 program 3 with readback
        do_reset(1'b0, '0, 1'b1);
        chk("R8", "default readback", int'(dout), DEPTH / 2);
        do_reset(1'b1, 9'd3, 1'b1);
        chk("R8", "readback", int'(dout), 3);
        for (int i = 0; i < 4; i++) strobe(1'b1, 1'b0, DW'(i));
        chk("R6", "hf_n after 4 words at thr 3", int'(hf_n), 0);
        chk_all("R6");

        // R7: idle reset keeps threshold
        do_reset(1'b0, '0, 1'b0);
        for (int i = 0; i < 3; i++) strobe(1'b1, 1'b0, DW'(i + 7));
        chk("R7", "hf_n at 3 words", int'(hf_n), 1);
        strobe(1'b1, 1'b0, 9'h0F0);
        chk("R7", "hf_n at 4 words", int'(hf_n), 0);
        do_reset(1'b0, '0, 1'b1);
        chk("R7", "readback after idle reset", int'(dout), 3);

        // R6/R8: full 9-bit threshold value
        do_reset(1'b1, 9'h1F5, 1'b1);
        chk("R6", "9-bit readback", int'(dout), 32'h1F5);
        for (int i = 0; i < DEPTH; i++) strobe(1'b1, 1'b0, DW'(i));
        chk("R9", "hf_n above-depth thr", int'(hf_n), 1);
        chk_all("R10");

        // Random mix with threshold 5
        do_reset(1'b1, 9'd5, 1'b0);
        for (int i = 0; i < 400; i++) begin
            int sel = int'($urandom % 4);
            strobe(sel[0] | (sel == 2'd2 ? 1'b0 : sel[1]), sel[1], DW'($urandom));
            chk_all("R1");
        end
        report();
    end
endmodule